// File: doc/BRIEF.md
# Stack Machine Conditional Branch Sequencer

This block is the microcoded slice of a small stack-machine core that carries out the conditional branch bytecodes and the unconditional jump. The main fetch loop reads an opcode, advances the program counter to the first operand byte and then hands the decoded opcode to this sequencer with a one-cycle start pulse. The sequencer owns the stack pointer, the cached top-of-stack word, a scratch register that holds either the popped condition or the branch base, an offset holding register and the program counter. When it has finished, it returns control with a one-cycle done pulse.

The two conditional forms each pop one word. The old top-of-stack value becomes the condition, and the top of stack is then refilled with a single read from the word-addressed stack memory at the decremented stack pointer. One form branches when the condition is zero and the other branches when it is negative. When the branch is taken, the sequencer fetches two operand bytes one at a time from the byte-addressed code memory. The first byte is taken as signed and the second as unsigned, and together they form a 16-bit signed offset. This offset is added to the address of the branch opcode. When the branch is not taken, both operand bytes are skipped. Both memories return data one cycle after the address is presented, and the sequencer waits for every read.

Top module: `branch_seq`

## Requirements
- R1: After reset, pc equals PC_RST (0x0200), sp equals SP_RST (0x80), tos is 0, and busy, done and err are low.
- R2: Opcode 0x99 (branch-if-zero) and opcode 0x9B (branch-if-negative) each lower sp by exactly one. They issue one data read with data_addr equal to the new sp, and tos takes the returned word.
- R3: Opcode 0x99 branches only when the tos value held before the pop equals zero.
- R4: Opcode 0x9B branches only when bit 31 of the tos value held before the pop is set.
- R5: On a taken branch, the offset is {first operand byte, second operand byte}, read as a 16-bit signed number. The new pc is (pc at start - 1) + offset, modulo 2^16.
- R6: On a branch that is not taken, the new pc is the pc at start + 2, and no code memory reads are issued.
- R7: Opcode 0xA7 (jump) always branches by the same offset rule as R5. It leaves sp and tos unchanged and issues no data read.
- R8: Any other opcode raises err together with done for one cycle, sets err_addr to the pc at start - 1, and leaves pc, sp and tos unchanged.
- R9: done is a single-cycle pulse that is raised once pc and tos are final. A start that arrives while busy is ignored.
- R10: Each read presents its address for one cycle with the strobe high, and the data is used in the following cycle. A taken branch issues exactly two code reads, one for each operand byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle launch pulse carrying opcode |
| opcode | input | 8 | Decoded opcode |
| code_rd | output | 1 | Code memory read strobe |
| code_addr | output | 16 | Byte address into code memory (the pc) |
| code_byte | input | 8 | Code byte, valid the cycle after code_rd |
| data_rd | output | 1 | Stack memory read strobe |
| data_addr | output | 8 | Word address into stack memory |
| data_word | input | 32 | Stack word, valid the cycle after data_rd |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Completion pulse |
| err | output | 1 | Unknown-opcode flag, raised with done |
| err_addr | output | 16 | Address of the faulting opcode |
| pc | output | 16 | Program counter |
| sp | output | 8 | Stack pointer in words |
| tos | output | 32 | Cached top-of-stack word |

## Verification
On every cycle, the embedded properties check the following. Every stack read targets the current stack pointer. The stack pointer only ever moves down by one. done never lasts two cycles, err never appears without done, and code reads never issue back to back. The bench scenarios alone show the decisions themselves: whether each condition value leads to a branch, and the sign handling of the two offset bytes. They also show the wrapped arithmetic of the new pc, the handling of an unknown opcode, and the fact that a start arriving mid-sequence has no effect on the final pc, sp and tos.

// File: rtl/branch_seq.sv
module branch_seq #(
  parameter int DW  = 32,
  parameter int CAW = 16,
  parameter int SAW = 8,
  parameter logic [7:0] OP_BZ  = 8'h99,
  parameter logic [7:0] OP_BN  = 8'h9B,
  parameter logic [7:0] OP_JMP = 8'hA7,
  parameter logic [CAW-1:0] PC_RST = CAW'(16'h0200),
  parameter logic [SAW-1:0] SP_RST = SAW'(8'h80)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [7:0]     opcode,
  output logic           code_rd,
  output logic [CAW-1:0] code_addr,
  input  logic [7:0]     code_byte,
  output logic           data_rd,
  output logic [SAW-1:0] data_addr,
  input  logic [DW-1:0]  data_word,
  output logic           busy,
  output logic           done,
  output logic           err,
  output logic [CAW-1:0] err_addr,
  output logic [CAW-1:0] pc,
  output logic [SAW-1:0] sp,
  output logic [DW-1:0]  tos
);

  typedef enum logic [2:0] {
    S_IDLE, S_POP, S_POPW, S_B1, S_B1W, S_B2, S_B2W, S_FIN
  } st_t;

  st_t            st;
  logic [CAW-1:0] pc_q, erra_q;
  logic [SAW-1:0] sp_q, mar_q;
  logic [DW-1:0]  tos_q, opc_q, h_q;
  logic           neg_q, err_q;

  logic [DW-1:0]  mbr_s, mbr_u, h_nxt, base_ext;
  logic           take;

  assign mbr_s    = {{(DW-8){code_byte[7]}}, code_byte};
  assign mbr_u    = {{(DW-8){1'b0}}, code_byte};
  assign h_nxt    = h_q | mbr_u;
  assign base_ext = {{(DW-CAW){1'b0}}, pc_q - CAW'(1)};
  assign take     = neg_q ? opc_q[DW-1] : (opc_q == '0);

  assign busy      = (st != S_IDLE);
  assign done      = (st == S_FIN);
  assign err       = done & err_q;
  assign err_addr  = erra_q;
  assign code_rd   = (st == S_B1) || (st == S_B2);
  assign code_addr = pc_q;
  assign data_rd   = (st == S_POP);
  assign data_addr = mar_q;
  assign pc        = pc_q;
  assign sp        = sp_q;
  assign tos       = tos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      pc_q   <= PC_RST;
      sp_q   <= SP_RST;
      mar_q  <= SP_RST;
      tos_q  <= '0;
      opc_q  <= '0;
      h_q    <= '0;
      neg_q  <= 1'b0;
      err_q  <= 1'b0;
      erra_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          err_q <= 1'b0;
          if (opcode == OP_BZ || opcode == OP_BN) begin
            sp_q  <= sp_q - SAW'(1);
            mar_q <= sp_q - SAW'(1);
            opc_q <= tos_q;
            neg_q <= (opcode == OP_BN);
            st    <= S_POP;
          end else if (opcode == OP_JMP) begin
            opc_q <= base_ext;
            st    <= S_B1;
          end else begin
            err_q  <= 1'b1;
            erra_q <= pc_q - CAW'(1);
            st     <= S_FIN;
          end
        end
        S_POP:  st <= S_POPW;
        S_POPW: begin
          tos_q <= data_word;
          if (take) begin
            opc_q <= base_ext;
            st    <= S_B1;
          end else begin
            pc_q <= pc_q + CAW'(2);
            st   <= S_FIN;
          end
        end
        S_B1: begin
          pc_q <= pc_q + CAW'(1);
          st   <= S_B1W;
        end
        S_B1W: begin
          h_q <= mbr_s << 8;
          st  <= S_B2;
        end
        S_B2: begin
          pc_q <= pc_q + CAW'(1);
          st   <= S_B2W;
        end
        S_B2W: begin
          h_q  <= h_nxt;
          pc_q <= opc_q[CAW-1:0] + h_nxt[CAW-1:0];
          st   <= S_FIN;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_pop_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd |-> data_addr == sp);

  assert_sp_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> sp == $past(sp) - SAW'(1));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_err_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  assert_fetch_wait_R10: assert property (@(posedge clk) disable iff (!rst_n)
    code_rd |=> !code_rd);

endmodule

// File: tb/tb_branch_seq.sv
module tb_branch_seq;
  localparam logic [7:0] BZ = 8'h99, BN = 8'h9B, JP = 8'hA7;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic        code_rd, data_rd, busy, done, err;
  logic [15:0] code_addr, err_addr, pc;
  logic [7:0]  data_addr, sp, code_q;
  logic [31:0] data_q, tos;

  logic [7:0]  code_mem [1024];
  logic [31:0] stk_mem  [256];

  int checks = 0, fails = 0;
  int n_code, n_data, n_done;
  logic [15:0] pc_m;
  logic [7:0]  sp_m;
  logic [31:0] tos_m;

  always #10 clk = ~clk;

  branch_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .code_rd(code_rd), .code_addr(code_addr), .code_byte(code_q),
    .data_rd(data_rd), .data_addr(data_addr), .data_word(data_q),
    .busy(busy), .done(done), .err(err), .err_addr(err_addr),
    .pc(pc), .sp(sp), .tos(tos)
  );

  always_ff @(posedge clk) begin
    if (code_rd) code_q <= code_mem[code_addr[9:0]];
    if (data_rd) data_q <= stk_mem[data_addr];
  end

  // op, offset, word to be refilled into tos
  localparam logic [55:0] VEC [14] = '{
    {BZ, 16'h0010, 32'h0000_0005},
    {BZ, 16'h0010, 32'h0000_0000},
    {BN, 16'hFFF0, 32'h8000_0000},
    {BN, 16'hFF00, 32'h0000_0007},
    {JP, 16'h0003, 32'h0000_0000},
    {JP, 16'h8000, 32'h0000_0000},
    {BN, 16'h7FFF, 32'hFFFF_FFFF},
    {BN, 16'h0080, 32'h0000_0001},
    {BZ, 16'h00FF, 32'h0000_0000},
    {BZ, 16'h01FF, 32'h0000_0009},
    {BN, 16'h1234, 32'h7FFF_FFFF},
    {BN, 16'h0003, 32'h0000_0000},
    {BZ, 16'hFF80, 32'h0000_0003},
    {JP, 16'h7FFF, 32'h0000_0000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic launch(input logic [7:0] op, input logic [15:0] off, input logic [31:0] fill,
                        input bit extra_start);
    code_mem[pc_m[9:0]]          = off[15:8];
    code_mem[10'(pc_m[9:0] + 1)] = off[7:0];
    stk_mem[sp_m - 8'd1]         = fill;
    n_code = 0; n_data = 0; n_done = 0;
    opcode = op; start = 1'b1;
    @(negedge clk);
    start = extra_start;
    opcode = BZ;
    for (int i = 0; i < 40; i++) begin
      if (code_rd) n_code++;
      if (data_rd) n_data++;
      if (done) break;
      @(negedge clk);
      start = 1'b0;
    end
    n_done = done ? 1 : 0;
  endtask

  task automatic run_vec(input logic [55:0] v, input bit extra_start);
    logic [7:0]  op;
    logic [15:0] off, base, exp_pc;
    logic [31:0] fill;
    bit          tk, cond;
    op = v[55:48]; off = v[47:32]; fill = v[31:0];
    base = pc_m - 16'd1;
    cond = (op != JP);
    tk = (op == JP) || (op == BZ && tos_m == 32'd0) || (op == BN && tos_m[31]);
    exp_pc = tk ? 16'(base + off) : 16'(pc_m + 16'd2);
    launch(op, off, fill, extra_start);
    if (cond) begin sp_m = sp_m - 8'd1; tos_m = fill; end
    pc_m = exp_pc;
    chk("R9 done seen", 32'(n_done), 32'd1);
    chk(op == JP ? "R7 pc" : (tk ? "R5 taken pc" : "R6 not-taken pc"), 32'(pc), 32'(pc_m));
    chk(op == BZ ? "R3 sp" : (op == BN ? "R4 sp" : "R7 sp"), 32'(sp), 32'(sp_m));
    chk(cond ? "R2 tos refill" : "R7 tos kept", tos, tos_m);
    chk(tk ? "R10 two code reads" : "R6 no code reads", 32'(n_code), tk ? 32'd2 : 32'd0);
    chk("R2 data reads", 32'(n_data), cond ? 32'd1 : 32'd0);
    chk("R8 err low", 32'(err), 32'd0);
    @(negedge clk);
    chk("R9 done single", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) code_mem[i] = 8'h00;
    for (int i = 0; i < 256; i++) stk_mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    chk("R1 pc", 32'(pc), 32'h0200);
    chk("R1 sp", 32'(sp), 32'h80);
    chk("R1 tos", tos, 32'h0);
    chk("R1 flags", {29'd0, busy, done, err}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    pc_m = 16'h0200; sp_m = 8'h80; tos_m = 32'h0;

    for (int k = 0; k < 14; k++) run_vec(VEC[k], 1'b0);

    // R8: unknown opcode
    launch(8'h3C, 16'h0000, 32'hDEAD_BEEF, 1'b0);
    chk("R8 err", 32'(err), 32'd1);
    chk("R8 done", 32'(done), 32'd1);
    chk("R8 err_addr", 32'(err_addr), 32'(16'(pc_m - 16'd1)));
    chk("R8 pc kept", 32'(pc), 32'(pc_m));
    chk("R8 sp kept", 32'(sp), 32'(sp_m));
    chk("R8 tos kept", tos, tos_m);
    @(negedge clk);
    chk("R8 err cleared", 32'(err), 32'd0);

    // R9: a second start while busy is ignored
    run_vec({JP, 16'h0040, 32'h0}, 1'b1);
    run_vec({BZ, 16'h0020, 32'h0000_0011}, 1'b1);
    chk("R9 idle after", 32'(busy), 32'd0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule